// File: doc/BRIEF.md
# Cursor Mask to Pixel Expander

This block turns a small two-plane monochrome cursor (a 16x16 grid, each row described by a "set" mask and a "clear" mask) into the 32x32, 16-bit-per-pixel cursor image that a display engine fetches. It walks through the whole output image once per start pulse. It emits one 32-bit word per accepted transfer on a simple valid/ready write port, with a word address that counts up from zero.

Each source pixel maps to a 16-bit code, and two codes share each output word. Every 16-pixel source row becomes a 32-pixel output row: the right half is padding filled with zero words. After the sixteen source rows, a fully blank lower half of the image is appended. When the final word has been accepted, a one-cycle done pulse follows. The host presents the masks on two flat input buses and keeps them stable from the start pulse until done. Enabling and disabling the cursor around a load is left to the host.

Top module: `cursor_expander`

## Requirements
- R1: While and directly after reset, `wr_valid` and `done` are 0 and `wr_addr` is 0.
- R2: A pixel whose set bit is 1 is written as 16'h8000, regardless of its clear bit. A pixel with only the clear bit at 1 is written as 16'hFFFF. A pixel with both bits at 0 is written as 16'h0000.
- R3: Row r of the source uses `set_rows[16*r +: 16]` and `clr_rows[16*r +: 16]`. Pixel 0 of a row is bit 15 of its mask and pixel 15 is bit 0. The word at address 16*r + c (c from 0 to 7) holds pixel 2c in bits 15:0 and pixel 2c+1 in bits 31:16.
- R4: Within the upper half (addresses 0 to 255), every word whose address has bit 3 set is zero. This pads each row to 32 pixels.
- R5: Addresses 256 to 511 carry zero words. A run contains exactly 512 words.
- R6: The first word of a run has address 0, and each accepted word is followed by the next address with no gaps. `done` is high for exactly one cycle, in the cycle after the word at address 511 is accepted, and `wr_valid` is low in that cycle.
- R7: A start pulse that arrives while a run is in progress has no effect on the address sequence or on the data.
- R8: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` keep their values into the next cycle.
- R9: A start pulse sampled while idle makes `wr_valid` high in the following cycle, with `wr_addr` equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a conversion; ignored while busy |
| set_rows | input | 256 | Set masks, 16 bits per row, row 0 in the lowest bits |
| clr_rows | input | 256 | Clear masks, same layout as set_rows |
| wr_ready | input | 1 | Cursor memory accepts the current word |
| wr_valid | output | 1 | A word is presented |
| wr_addr | output | 9 | Word address in the cursor memory |
| wr_data | output | 32 | Two packed 16-bit pixels |
| done | output | 1 | One-cycle pulse after the last word is accepted |

## Verification
The first word is due one cycle after the start pulse is sampled. Each later word is due one cycle after the previous word is accepted. The done pulse is due one cycle after the transfer at address 511. The bench samples every output on the falling edge. A scoreboard pops one expected word per observed transfer, so a random stall on `wr_ready` never shifts the comparison. The hold check compares each stalled cycle with the values sampled on the falling edge before it. The done check fires on the falling edge that follows the final transfer and at no other time.

// File: rtl/cexp_pkg.sv
package cexp_pkg;
    parameter int GRID          = 16;
    parameter int PIX_W         = 16;
    parameter int PIX_PER_WORD  = 2;
    parameter int WORD_W        = PIX_W * PIX_PER_WORD;
    parameter int OUT_SIDE      = 2 * GRID;
    parameter int WORDS_PER_ROW = OUT_SIDE / PIX_PER_WORD;
    parameter int DATA_WORDS    = GRID / PIX_PER_WORD;
    parameter int TOTAL_WORDS   = OUT_SIDE * OUT_SIDE / PIX_PER_WORD;
    parameter int ADDR_W        = $clog2(TOTAL_WORDS);
    parameter int COL_W         = $clog2(WORDS_PER_ROW);
    parameter int ROW_W         = $clog2(GRID);
    parameter int MASK_BITS     = GRID * GRID;
    parameter int UPPER_WORDS   = GRID * WORDS_PER_ROW;

    typedef logic [PIX_W-1:0]  pix_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [1:0] {
        PK_BLANK  = 2'd0,
        PK_INVERT = 2'd1,
        PK_SOLID  = 2'd2
    } pix_kind_e;

    typedef struct packed {
        logic             upper;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } word_pos_t;

    function automatic pix_kind_e classify(input logic s, input logic c);
        if (s)      return PK_SOLID;
        else if (c) return PK_INVERT;
        else        return PK_BLANK;
    endfunction

    function automatic pix_t kind_value(input pix_kind_e k);
        case (k)
            PK_SOLID:  return {1'b1, {(PIX_W-1){1'b0}}};
            PK_INVERT: return {PIX_W{1'b1}};
            default:   return '0;
        endcase
    endfunction

    function automatic word_pos_t locate(input addr_t a);
        word_pos_t p;
        p.upper = (int'(a) < UPPER_WORDS);
        p.col   = a[COL_W-1:0];
        p.row   = a[COL_W +: ROW_W];
        return p;
    endfunction
endpackage

// File: rtl/cexp_seq.sv
module cexp_seq
    import cexp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  ready,
    output logic  valid,
    output addr_t addr,
    output logic  done
);
    localparam addr_t LAST = addr_t'(TOTAL_WORDS - 1);

    logic busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            addr <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy <= 1'b1;
                    addr <= '0;
                end
            end else if (ready) begin
                if (addr == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    addr <= '0;
                end else begin
                    addr <= addr + 1'b1;
                end
            end
        end
    end

    assign valid = busy;

    // R6: address advances by one per accepted word
    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        valid && ready && addr != LAST |=> valid && addr == $past(addr) + 1'b1);
    // R6: done follows the final transfer
    a_r6_done_after_last: assert property (@(posedge clk) disable iff (rst)
        valid && ready && addr == LAST |=> done && !valid);
    // R7: a start during a run does not restart the address
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
        valid && start && !ready |=> addr == $past(addr));
    // R9: start while idle opens a run at address zero
    a_r9_start_opens: assert property (@(posedge clk) disable iff (rst)
        !valid && start |=> valid && addr == '0);
endmodule

// File: rtl/cexp_encode.sv
module cexp_encode
    import cexp_pkg::*;
(
    input  logic [MASK_BITS-1:0] set_rows,
    input  logic [MASK_BITS-1:0] clr_rows,
    input  addr_t                addr,
    output word_t                word
);
    word_pos_t        pos;
    logic             in_data;
    logic [GRID-1:0]  row_set;
    logic [GRID-1:0]  row_clr;

    always_comb begin
        pos     = locate(addr);
        in_data = pos.upper && (int'(pos.col) < DATA_WORDS);
        row_set = set_rows[int'(pos.row)*GRID +: GRID];
        row_clr = clr_rows[int'(pos.row)*GRID +: GRID];
    end

    for (genvar j = 0; j < PIX_PER_WORD; j++) begin : g_pix
        logic [ROW_W-1:0] bit_idx;
        pix_kind_e        kind;
        always_comb begin
            bit_idx = ROW_W'(GRID - 1 - (int'(pos.col) * PIX_PER_WORD + j));
            if (in_data)
                kind = classify(row_set[bit_idx], row_clr[bit_idx]);
            else
                kind = PK_BLANK;
        end
        assign word[j*PIX_W +: PIX_W] = kind_value(kind);
    end
endmodule

// File: rtl/cursor_expander.sv
module cursor_expander
    import cexp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MASK_BITS-1:0] set_rows,
    input  logic [MASK_BITS-1:0] clr_rows,
    input  logic                 wr_ready,
    output logic                 wr_valid,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic [WORD_W-1:0]    wr_data,
    output logic                 done
);
    cexp_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ready (wr_ready),
        .valid (wr_valid),
        .addr  (wr_addr),
        .done  (done)
    );

    cexp_encode u_enc (
        .set_rows (set_rows),
        .clr_rows (clr_rows),
        .addr     (wr_addr),
        .word     (wr_data)
    );

    // R8: a stalled word holds
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));
    // R4: padding words are zero
    a_r4_pad_zero: assert property (@(posedge clk) disable iff (rst)
        wr_valid && int'(wr_addr) < UPPER_WORDS && wr_addr[COL_W-1] |-> wr_data == '0);
    // R5: lower half is blank
    a_r5_tail_zero: assert property (@(posedge clk) disable iff (rst)
        wr_valid && int'(wr_addr) >= UPPER_WORDS |-> wr_data == '0);
    // R6: done is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: tb/cursor_expander_test.sv
module cursor_expander_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [255:0] set_rows = '0;
    logic [255:0] clr_rows = '0;
    logic         wr_ready = 1'b1;
    logic         wr_valid;
    logic [8:0]   wr_addr;
    logic [31:0]  wr_data;
    logic         done;

    int total = 0;
    int bad = 0;
    int stall_mode = 0;
    logic [40:0] expq[$];
    logic        done_due = 1'b0;
    logic        prev_stall = 1'b0;
    logic [8:0]  prev_addr = '0;
    logic [31:0] prev_data = '0;
    int          words_seen = 0;

    always #2 clk = ~clk;

    cursor_expander uut (
        .clk(clk), .rst(rst), .start(start),
        .set_rows(set_rows), .clr_rows(clr_rows),
        .wr_ready(wr_ready), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] pix(input logic s, input logic c);
        if (s) return 16'h8000;
        if (c) return 16'hFFFF;
        return 16'h0000;
    endfunction

    function automatic logic [31:0] model(input logic [255:0] sm, input logic [255:0] cm, input int a);
        int r, c;
        if (a >= 256) return 32'h0;
        r = a / 16;
        c = a % 16;
        if (c >= 8) return 32'h0;
        return {pix(sm[16*r + 15 - (2*c+1)], cm[16*r + 15 - (2*c+1)]),
                pix(sm[16*r + 15 - 2*c],     cm[16*r + 15 - 2*c])};
    endfunction

    always @(posedge clk) begin
        #1;
        if (stall_mode != 0) wr_ready <= ($urandom % 3) != 0;
        else                 wr_ready <= 1'b1;
    end

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (done_due) begin
                check(done === 1'b1 && wr_valid === 1'b0, "R6 done after last", {62'b0, done, wr_valid}, 64'h2);
                done_due = 1'b0;
            end else if (done === 1'b1) begin
                check(1'b0, "R6 stray done", 64'h1, 64'h0);
            end
            if (prev_stall) begin
                check(wr_valid === 1'b1 && wr_addr === prev_addr && wr_data === prev_data,
                      "R8 hold", {wr_addr, wr_data}, {prev_addr, prev_data});
            end
            prev_stall = wr_valid && !wr_ready;
            prev_addr  = wr_addr;
            prev_data  = wr_data;
            if (wr_valid === 1'b1 && wr_ready === 1'b1) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R5 extra word", {55'b0, wr_addr}, 64'h0);
                end else begin
                    logic [40:0] e;
                    e = expq.pop_front();
                    check({wr_addr, wr_data} === e, "R2 R3 R4 R5 R6 word", {wr_addr, wr_data}, e);
                    words_seen++;
                    if (e[40:32] == 9'd511) done_due = 1'b1;
                end
            end
        end
    end

    task automatic run_image(input logic [255:0] sm, input logic [255:0] cm, input int mode, input bit poke);
        set_rows = sm;
        clr_rows = cm;
        stall_mode = mode;
        words_seen = 0;
        for (int a = 0; a < 512; a++) expq.push_back({9'(a), model(sm, cm, a)});
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        @(negedge clk);
        check(wr_valid === 1'b1 && wr_addr === 9'd0, "R9 first word", {55'b0, wr_addr}, 64'h0);
        if (poke) begin
            repeat (40) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
            repeat (100) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        @(posedge done);
        @(negedge clk); @(negedge clk);
        check(expq.size() == 0 && words_seen == 512, "R5 R7 word count", 64'(words_seen), 64'd512);
        stall_mode = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        int cyc = 0;
        fork
            begin
                while (cyc < 100000) begin @(posedge clk); cyc++; end
                check(1'b0, "watchdog", 64'(cyc), 64'd0);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        join_none
    end

    initial begin
        logic [255:0] rs, rc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_valid === 1'b0 && done === 1'b0 && wr_addr === 9'd0, "R1 during reset",
              {54'b0, wr_valid, done, wr_addr}, 64'h0);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(wr_valid === 1'b0 && done === 1'b0 && wr_addr === 9'd0, "R1 after reset",
              {54'b0, wr_valid, done, wr_addr}, 64'h0);
        // R2 blank image
        run_image('0, '0, 0, 1'b0);
        // R2 set wins over clear
        run_image('1, '1, 0, 1'b0);
        // R2 clear only
        run_image('0, '1, 1, 1'b0);
        // R3 single-pixel ordering probes
        run_image({240'b0, 16'h8001}, {224'b0, 16'h4002, 16'h0}, 0, 1'b0);
        // R7 R8 random masks, random stalls, extra starts mid-run
        for (int k = 0; k < 8; k++) begin
            rs[32*k +: 32] = $urandom;
            rc[32*k +: 32] = $urandom;
        end
        run_image(rs, rc, 1, 1'b1);
        // R3 checkerboard
        run_image({16{16'hAAAA}}, {16{16'h5555}}, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule